// File: doc/BRIEF.md
# Address-generation shift-add unit

This unit produces array-element addresses in one step: it takes an index operand, scales it by 2, 4 or 8 with a short left shift, and adds a base operand. In the 64-bit build it also offers forms that treat the index as an unsigned 32-bit word, zero-extending its low half before the shift and the add. There is also a form that adds such a zero-extended word with no scaling, and an immediate left shift of a zero-extended word with no add at all. None of the operations can trap, and every operand value is accepted.

The datapath is combinational. A parameter can add one register stage, which has a valid qualifier and a clock enable. In the 32-bit build only the three plain scale-and-add forms exist. Selecting any other operation there forces the result to zero and raises an illegal-operation flag for the surrounding decode logic.

Top module: `agu_shadd`

## Requirements
- R1: Operation codes 1, 2 and 3 return `base + (index << k)` with k equal to the code. The low k bits of the result therefore equal the low k bits of `base`.
- R2: When XLEN is 64, operation codes 5, 6 and 7 return `base + ({32'b0, index[31:0]} << k)`, where k is the code minus 4. The upper half of `index` has no effect.
- R3: When XLEN is 64, operation code 4 returns `base + {32'b0, index[31:0]}`.
- R4: When XLEN is 64, operation code 0 returns `{32'b0, index[31:0]} << shamt`, where shamt is 6 bits wide. `base` is ignored, a shamt of 0 returns the zero-extended word unchanged, and bits shifted past bit 63 are lost.
- R5: Every sum wraps modulo 2^XLEN, and there is no carry or overflow output.
- R6: When XLEN is 32, operation codes 0, 4, 5, 6 and 7 give a zero result with `illegal` high, and codes 1 to 3 give `illegal` low. When XLEN is 64, `illegal` is never high.
- R7: With REG_OUT = 0, `out_valid` equals `in_valid`, and `result` follows the inputs within the same cycle.
- R8: With REG_OUT = 1, `result`, `illegal` and `out_valid` appear one clock edge after the inputs are presented.
- R9: With REG_OUT = 1, a cycle with `in_valid` low leaves `result` and `illegal` unchanged.
- R10: With REG_OUT = 1, an active reset clears `out_valid`, `result` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op_sel | input | 3 | Operation code (see R1 to R4) |
| shamt | input | 6 | Immediate shift amount for code 0 |
| index | input | XLEN | Operand that is scaled or extended |
| base | input | XLEN | Operand added to the scaled index |
| result | output | XLEN | Computed address or shifted word |
| illegal | output | 1 | Operation not available in this width |
| out_valid | output | 1 | `result` is meaningful |

## Verification
On every cycle the assertions check four behaviours. An illegal result is zero. The 64-bit build never raises `illegal`. The valid qualifier passes through or is delayed as the stage parameter demands, and a registered stage holds its result when idle. The low bits of a scale-by-8 sum also match the base. The actual arithmetic values come only from the bench's scenarios. These include the zero-extension of the low word, wraparound, immediate shift edges at 0, 32, 40 and 63, and reset.

// File: rtl/agu_shadd_pkg.sv
package agu_shadd_pkg;

  localparam int WORD_W  = 32;
  localparam int SHAMT_W = 6;

  typedef enum logic [2:0] {
    OP_SLLI_UW   = 3'd0,
    OP_SH1ADD    = 3'd1,
    OP_SH2ADD    = 3'd2,
    OP_SH3ADD    = 3'd3,
    OP_ADD_UW    = 3'd4,
    OP_SH1ADD_UW = 3'd5,
    OP_SH2ADD_UW = 3'd6,
    OP_SH3ADD_UW = 3'd7
  } agu_op_e;

  typedef struct packed {
    logic       zext;       // take the zero-extended low word of index
    logic [1:0] scale;      // pre-adder shift amount
    logic       imm_shift;  // immediate shift path, no add
    logic       illegal;    // code not offered in this width
  } agu_ctl_t;

endpackage

// File: rtl/agu_shadd_dec.sv
module agu_shadd_dec
  import agu_shadd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0] op_sel,
  output agu_ctl_t   ctl
);

  localparam bit WIDE = (XLEN > WORD_W);

  always_comb begin
    ctl.zext      = op_sel[2] | (op_sel == OP_SLLI_UW);
    ctl.scale     = op_sel[1:0];
    ctl.imm_shift = (op_sel == OP_SLLI_UW);
    if (WIDE) begin
      ctl.illegal = 1'b0;
    end else begin
      ctl.illegal = op_sel[2] | (op_sel[1:0] == 2'd0);
    end
  end

endmodule

// File: rtl/agu_shadd_pre.sv
module agu_shadd_pre
  import agu_shadd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] index,
  input  logic            zext,
  input  logic [1:0]      scale,
  output logic [XLEN-1:0] src,
  output logic [XLEN-1:0] addend
);

  generate
    if (XLEN > WORD_W) begin : g_wide
      assign src = zext ? {{(XLEN-WORD_W){1'b0}}, index[WORD_W-1:0]} : index;
    end else begin : g_narrow
      logic unused_zext;
      assign unused_zext = zext;
      assign src = index;
    end
  endgenerate

  // Four-way mux in front of the adder; no general shifter on this path.
  always_comb begin
    unique case (scale)
      2'd0:    addend = src;
      2'd1:    addend = {src[XLEN-2:0], 1'b0};
      2'd2:    addend = {src[XLEN-3:0], 2'b0};
      default: addend = {src[XLEN-4:0], 3'b0};
    endcase
  end

endmodule

// File: rtl/agu_shadd_out.sv
module agu_shadd_out #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] res_c,
  input  logic            ill_c,
  output logic [XLEN-1:0] result,
  output logic            illegal,
  output logic            out_valid
);

  generate
    if (REG_OUT) begin : g_reg
      logic [XLEN-1:0] res_d, res_q;
      logic            ill_d, ill_q;
      logic            vld_d, vld_q;

      always_comb begin
        vld_d = in_valid;
        res_d = res_q;
        ill_d = ill_q;
        if (in_valid) begin
          res_d = res_c;
          ill_d = ill_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          ill_q <= 1'b0;
        end else begin
          vld_q <= vld_d;
          res_q <= res_d;
          ill_q <= ill_d;
        end
      end

      assign result    = res_q;
      assign illegal   = ill_q;
      assign out_valid = vld_q;
    end else begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign result    = res_c;
      assign illegal   = ill_c;
      assign out_valid = in_valid;
    end
  endgenerate

endmodule

// File: rtl/agu_shadd.sv
module agu_shadd
  import agu_shadd_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op_sel,
  input  logic [SHAMT_W-1:0]  shamt,
  input  logic [XLEN-1:0]     index,
  input  logic [XLEN-1:0]     base,
  output logic [XLEN-1:0]     result,
  output logic                illegal,
  output logic                out_valid
);

  agu_ctl_t        ctl;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] addend;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] res_c;

  agu_shadd_dec #(.XLEN(XLEN)) u_dec (
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  agu_shadd_pre #(.XLEN(XLEN)) u_pre (
    .index  (index),
    .zext   (ctl.zext),
    .scale  (ctl.scale),
    .src    (src),
    .addend (addend)
  );

  // Carry out of the top bit is dropped: modulo 2^XLEN.
  assign sum     = base + addend;
  assign shifted = src << shamt;

  always_comb begin
    if (ctl.illegal) begin
      res_c = '0;
    end else if (ctl.imm_shift) begin
      res_c = shifted;
    end else begin
      res_c = sum;
    end
  end

  agu_shadd_out #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_c     (res_c),
    .ill_c     (ctl.illegal),
    .result    (result),
    .illegal   (illegal),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/agu_shadd_chk.sv
module agu_shadd_chk #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op_sel,
  input logic [XLEN-1:0] base,
  input logic [XLEN-1:0] result,
  input logic            illegal,
  input logic            out_valid
);

  // R6: a flagged operation never leaks a value
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  generate
    if (XLEN > 32) begin : g_wide
      // R6: every code exists in the wide build
      p_never_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal);
    end

    if (REG_OUT) begin : g_reg
      // R8: qualifier delayed by one edge
      p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R9: idle cycle holds the stage
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
      // R1: scale by 8 keeps the base's low three bits
      p_sh3_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd3) |=> (result[2:0] == $past(base[2:0])));
    end else begin : g_comb
      // R7: qualifier passes straight through
      p_valid_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      // R1: scale by 8 keeps the base's low three bits
      p_sh3_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3) |-> (result[2:0] == base[2:0]));
      if (XLEN <= 32) begin : g_narrow
        // R6: plain scale-and-add codes are accepted
        p_legal_ops_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (op_sel inside {3'd1, 3'd2, 3'd3}) |-> !illegal);
      end
    end
  endgenerate

endmodule

bind agu_shadd agu_shadd_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .base      (base),
  .result    (result),
  .illegal   (illegal),
  .out_valid (out_valid)
);

// File: tb/sim_agu_shadd.sv
`timescale 1ns/1ps
module sim_agu_shadd;

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  sh;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 6'd0,  64'd5, 64'd7, 64'd17},
    '{3'd2, 6'd0,  64'd5, 64'd7, 64'd27},
    '{3'd3, 6'd0,  64'd5, 64'd7, 64'd47},
    '{3'd3, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 64'd0},                      // R5
    '{3'd5, 6'd0,  64'hFFFF_FFFF_8000_0000, 64'd1, 64'h0000_0001_0000_0001},
    '{3'd6, 6'd0,  64'h1234_5678_0000_0003, 64'h10, 64'h1C},
    '{3'd7, 6'd0,  64'hAAAA_AAAA_FFFF_FFFF, 64'd0, 64'h0000_0007_FFFF_FFF8},
    '{3'd4, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h0000_0001_0000_0000},
    '{3'd0, 6'd0,  64'hDEAD_BEEF_1234_5678, 64'hFFFF, 64'h0000_0000_1234_5678},
    '{3'd0, 6'd32, 64'hDEAD_BEEF_1234_5678, 64'hFFFF, 64'h1234_5678_0000_0000},
    '{3'd0, 6'd63, 64'hFFFF_FFFF_0000_0001, 64'hFFFF, 64'h8000_0000_0000_0000},
    '{3'd0, 6'd40, 64'h0000_0000_FFFF_FFFF, 64'h1234, 64'hFFFF_FF00_0000_0000},
    '{3'd1, 6'd0,  64'h8000_0000_0000_0000, 64'd3, 64'd3}                       // R5
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [5:0]  shamt;
  logic [63:0] index;
  logic [63:0] base;
  logic [63:0] res0;
  logic        ill0, vld0;
  logic [31:0] res1;
  logic        ill1, vld1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  agu_shadd #(.XLEN(64), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .shamt(shamt), .index(index), .base(base),
    .result(res0), .illegal(ill0), .out_valid(vld0));

  agu_shadd #(.XLEN(32), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .shamt(shamt), .index(index[31:0]), .base(base[31:0]),
    .result(res1), .illegal(ill1), .out_valid(vld1));

  function automatic logic [63:0] ref64(logic [2:0] op, logic [5:0] sh,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] z;
    z = {32'b0, a[31:0]};
    case (op)
      3'd0: return z << sh;
      3'd1: return b + (a << 1);
      3'd2: return b + (a << 2);
      3'd3: return b + (a << 3);
      3'd4: return b + z;
      3'd5: return b + (z << 1);
      3'd6: return b + (z << 2);
      default: return b + (z << 3);
    endcase
  endfunction

  function automatic logic [31:0] ref32(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd1: return b + (a << 1);
      3'd2: return b + (a << 2);
      3'd3: return b + (a << 3);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [5:0] sh, logic [63:0] a,
                       logic [63:0] b, logic v);
    @(negedge clk);
    op_sel = op; shamt = sh; index = a; base = b; in_valid = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 3'd1; shamt = '0; index = '0; base = '0;
    repeat (3) @(negedge clk);
    // R10: reset state of the registered build
    chk("R10", {61'd0, vld0, ill0, |res0}, 64'd0);
    rst_n = 1'b1;

    // Table walk on the wide registered build
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      drive(VECS[i].op, VECS[i].sh, VECS[i].a, VECS[i].b, 1'b1);
      @(negedge clk);
      if (i == 3 || i == 12)             tag = "R5";
      else if (VECS[i].op == 3'd0)       tag = "R4";
      else if (VECS[i].op == 3'd4)       tag = "R3";
      else if (VECS[i].op[2])            tag = "R2";
      else                               tag = "R1";
      chk(tag, res0, VECS[i].exp);
      chk("R8", {63'd0, vld0}, 64'd1);
    end

    // R9: idle cycle keeps the last result
    drive(3'd2, 6'd0, 64'h55, 64'h66, 1'b0);
    @(negedge clk);
    chk("R9", res0, 64'd3);
    chk("R8", {63'd0, vld0}, 64'd0);
    chk("R7", {63'd0, vld1}, 64'd0);

    // R8: output only after the edge
    drive(3'd1, 6'd0, 64'd10, 64'd1, 1'b1);
    #1;
    chk("R8", {63'd0, vld0}, 64'd0);
    chk("R7", {63'd0, vld1}, 64'd1);
    chk("R7", {32'd0, res1}, 64'd21);
    @(negedge clk);
    chk("R8", res0, 64'd21);

    // R6: narrow build code coverage
    for (int op = 0; op < 8; op++) begin
      logic legal;
      drive(op[2:0], 6'd5, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0100, 1'b1);
      @(negedge clk);
      legal = (op >= 1 && op <= 3);
      chk("R6", {63'd0, ill1}, {63'd0, !legal});
      chk("R6", {32'd0, res1}, {32'd0, ref32(op[2:0], 32'd3, 32'h100)});
      chk("R6", {63'd0, ill0}, 64'd0);
    end

    // Random operands in both widths (R1, R2, R3, R4)
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  rop;
      logic [5:0]  rsh;
      logic [63:0] ra, rb;
      rop = 3'($urandom); rsh = 6'($urandom);
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      drive(rop, rsh, ra, rb, 1'b1);
      @(negedge clk);
      chk(rop[2] ? "R2" : (rop == 3'd0 ? "R4" : "R1"), res0, ref64(rop, rsh, ra, rb));
      chk("R1", {32'd0, res1}, {32'd0, ref32(rop, ra[31:0], rb[31:0])});
    end

    // R10: asynchronous reset in mid-run
    drive(3'd3, 6'd0, 64'd9, 64'd9, 1'b1);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", {61'd0, vld0, ill0, |res0}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule